// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address of a synchronous memory on every clock cycle of a burst access. A burst begins when an external address is captured. Two active-low address strobes can start it: one comes from the processor and one from the cache controller. After the capture, the two least significant address bits step through a group of four beats. A step happens only on cycles where the active-low advance input is asserted. The bits above those two stay fixed until the next capture.

A static order input selects how the beats are visited. When it is low, the sequence is linear: the low bits count up by one and wrap inside the aligned group of four. When it is high, the sequence is interleaved: the low bits are the start value XORed with the beat number. Bursting is optional. A new address can be captured on every cycle, and it appears at the output on the very next cycle with no dead cycle in between. A valid flag tells downstream logic that an address has been captured since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-low reset is applied, and at the first edge after it, the address output is all zeros and the valid flag is 0.
- R2: A low controller strobe at a clock edge captures the external address whatever the chip-enable level. From the next cycle the output equals that address and the valid flag is 1.
- R3: A low processor strobe captures the external address only while chip enable is low. While chip enable is high, a lone processor strobe leaves the output unchanged.
- R4: At an edge where advance is low, the valid flag is 1 and no capture happens, the beat count (0 to 3) increments modulo 4.
- R5: With the order input low (linear), output bits [1:0] equal (start bits [1:0] + beat) modulo 4.
- R6: With the order input high (interleaved), output bits [1:0] equal start bits [1:0] XOR beat.
- R7: Output bits above bit 1 keep the captured value for the whole burst, including when the low bits wrap past beat 3.
- R8: When a capture and an advance happen at the same edge, the capture wins. The new address appears with beat 0.
- R9: When neither a capture nor an advance happens at an edge, the output and the valid flag hold their values.
- R10: Captures on consecutive edges each produce their own address on the following cycle, with no extra cycle between them.
- R11: An advance before any capture since reset has no effect. The output stays zero and the valid flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | ADDR_W | External address to capture |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, not gated |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| order_lin_n | input | 1 | Burst order: 0 selects linear, 1 selects interleaved |
| cur_addr | output | ADDR_W | Current internal address |
| addr_valid | output | 1 | An address has been captured since reset |

## Verification
The output depends on the order input combinationally. The step and hold properties therefore assume that this input stays stable across the cycle they examine: each one tests the order level before comparing addresses, and a property that follows the linear count fires only when linear order holds on both sides of the step. The properties also assume that every input is driven to a known level at each edge. The stimulus changes the order input only between bursts, away from the clock edge, and drives every control input on every cycle. It sweeps all sixteen combinations of the four control inputs in both orders, starting from states that were captured and from states that were not.

// File: rtl/burst_seq_pkg.sv
// Shared definitions for the burst address sequencer.
// Assumes the burst counter covers a group of four beats.
package burst_seq_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_strobe_decode.sv
// Decodes the address strobes, chip enable and advance into one capture
// request and one step request. A capture always overrides a step.
// Assumes all inputs are synchronous to the consuming clock.
module burst_strobe_decode (
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic ce_n,
    input  logic adv_n,
    input  logic seq_valid,
    output logic load,
    output logic step
);
    // Capture on controller strobe, or processor strobe while enabled; step otherwise.
    always_comb begin
        load = (!ctrl_strobe_n) || (!proc_strobe_n && !ce_n);
        step = !load && !adv_n && seq_valid;
    end
endmodule

// File: rtl/burst_beat_counter.sv
// Holds the captured start address and the beat count of the current burst.
// Assumes load and step are never both active (decoded upstream).
module burst_beat_counter
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_addr,
    output beat_t             beat,
    output logic              seq_valid
);
    // Capture the start address, advance the beat, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            beat      <= '0;
            seq_valid <= 1'b0;
        end else if (load) begin
            base_addr <= ext_addr;
            beat      <= '0;
            seq_valid <= 1'b1;
        end else if (step) begin
            beat      <= beat + beat_t'(1);
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (base_addr == $past(ext_addr)) && (beat == '0) && seq_valid);

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (beat == beat_t'($past(beat) + beat_t'(1))) && $stable(base_addr));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(base_addr) && $stable(beat) && $stable(seq_valid));
endmodule

// File: rtl/burst_order_map.sv
// Maps start address and beat count to the current address in the selected
// order. Assumes order is a static configuration level.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  beat_t             beat,
    input  order_e            order,
    output logic [ADDR_W-1:0] mapped_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    beat_t lin_low;
    beat_t ilv_low;

    // Linear order: modulo-4 sum of start bits and beat.
    always_comb lin_low = base_addr[BEAT_W-1:0] + beat;

    // Interleaved order: per-bit XOR of start bits and beat.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = base_addr[b] ^ beat[b];
    end

    // Select the low bits by order and keep the upper bits as captured.
    always_comb begin
        mapped_addr[ADDR_W-1:BEAT_W] = base_addr[ADDR_W-1:BEAT_W];
        mapped_addr[BEAT_W-1:0]      = (order == ORDER_LINEAR) ? lin_low : ilv_low;
    end

    initial begin
        if (HI_W < 1) $error("ADDR_W must exceed the beat width");
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: captures an external address on either
// strobe and steps its two low bits in linear or interleaved order.
// Assumes order_lin_n is held steady for the length of a burst.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              addr_valid
);
    logic              load;
    logic              step;
    logic              seq_valid;
    logic [ADDR_W-1:0] base_addr;
    beat_t             beat;
    order_e            order;

    // Translate the order pin into the order type.
    always_comb order = order_lin_n ? ORDER_INTERLEAVE : ORDER_LINEAR;

    burst_strobe_decode u_decode (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .ce_n          (ce_n),
        .adv_n         (adv_n),
        .seq_valid     (seq_valid),
        .load          (load),
        .step          (step)
    );

    burst_beat_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .ext_addr  (ext_addr),
        .base_addr (base_addr),
        .beat      (beat),
        .seq_valid (seq_valid)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base_addr   (base_addr),
        .beat        (beat),
        .order       (order),
        .mapped_addr (cur_addr)
    );

    // Expose the capture flag at the port.
    always_comb addr_valid = seq_valid;

    // R3
    proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && ce_n && ctrl_strobe_n && adv_n)
        |=> (!$stable(order_lin_n) || $stable(cur_addr)));

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe_n && (proc_strobe_n || ce_n))
        |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_n && ctrl_strobe_n && (proc_strobe_n || ce_n) && addr_valid && !order_lin_n)
        |=> (order_lin_n || (cur_addr[BEAT_W-1:0] == beat_t'($past(cur_addr[BEAT_W-1:0]) + beat_t'(1)))));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !adv_n) |=> (base_addr == $past(ext_addr)) && (beat == '0));

    // R11
    no_step_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && ctrl_strobe_n && (proc_strobe_n || ce_n))
        |=> !addr_valid && (cur_addr == '0));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          proc_strobe_n, ctrl_strobe_n, adv_n, ce_n, order_lin_n;
    logic [AW-1:0] cur_addr;
    logic          addr_valid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    logic          m_valid;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .ce_n(ce_n), .order_lin_n(order_lin_n),
        .cur_addr(cur_addr), .addr_valid(addr_valid)
    );

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_lin_n ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string tag);
        logic [AW-1:0] e;
        e = m_valid ? exp_addr() : '0;
        n_chk++;
        if (cur_addr !== e || addr_valid !== m_valid) begin
            n_fail++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     tag, cur_addr, addr_valid, e, m_valid);
        end
    endtask

    // Drive one cycle's inputs, clock it, update the model and check.
    task automatic cyc(input logic [AW-1:0] a, input logic p, input logic c,
                       input logic v, input logic e, input string tag);
        logic ld;
        @(negedge clk);
        ext_addr = a; proc_strobe_n = p; ctrl_strobe_n = c; adv_n = v; ce_n = e;
        @(posedge clk);
        #1;
        ld = !c || (!p && !e);
        if (ld) begin
            m_base = a; m_beat = 2'd0; m_valid = 1'b1;
        end else if (!v && m_valid) begin
            m_beat = m_beat + 2'd1;
        end
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1; ce_n = 1'b1;
        ext_addr = '0;
        @(posedge clk); @(posedge clk); #1;
        m_base = '0; m_beat = '0; m_valid = 1'b0;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        order_lin_n = 1'b1;
        do_reset();
        // R11: advances before any capture change nothing
        cyc(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, "R11");
        cyc(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        // Sweep both orders, all starts, several upper patterns, with wrap
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            order_lin_n = m[0];
            for (int up = 0; up < 64; up += 21) begin
                for (int s = 0; s < 4; s++) begin
                    cyc(AW'(up * 4 + s), 1'b1, 1'b0, 1'b1, 1'b1, "R2");
                    for (int k = 0; k < 5; k++) begin
                        cyc(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, m[0] ? "R6" : "R5");
                        cyc(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
                    end
                    check("R7");
                end
            end
        end
        // R3: processor strobe gated by chip enable
        order_lin_n = 1'b0;
        cyc(8'h21, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        cyc(8'h33, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        // R8: capture beats advance at the same edge
        cyc(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
        cyc(8'h46, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        cyc(8'h47, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        // R10: back-to-back captures
        for (int i = 0; i < 8; i++)
            cyc(AW'(8'h90 + i * 7), i[0], !i[0], 1'b1, 1'b0, "R10");
        // All control combinations in both orders, from captured and uncaptured states
        for (int m = 0; m < 2; m++) begin
            for (int st = 0; st < 2; st++) begin
                do_reset();
                @(negedge clk);
                order_lin_n = m[0];
                if (st == 1) cyc(8'hC6, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
                for (int cmb = 0; cmb < 16; cmb++) begin
                    cyc(AW'(8'h3C ^ cmb), cmb[0], cmb[1], cmb[2], cmb[3], "R8");
                    cyc(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule